// File: doc/BRIEF.md
# Serial Flash Command Engine

This block is a register-driven engine that runs exactly one serial-flash command each time software asks for one. Software first fills in an opcode register and an address register. For a program-style command it also loads the payload into a word-organised data buffer. It then writes a configuration word whose lowest bit starts the command. The engine selects one of four flash devices, drives a single-line mode 0 serial clock and data out, and samples data in. It sends the opcode, an optional three-byte address, an optional run of dummy bytes and an optional data phase. Bytes received in the data phase are packed into the buffer.

The start bit doubles as the busy flag, so software polls the configuration word until the bit drops to zero. It then reads the received bytes from the buffer. The buffer depth is tied to the identification value the block reports. The identification value is a parameter and is read back unchanged through a read-only register.

Top module: `sfc_cmd_engine`

## Requirements
- R1: Register offsets are: identification 0x1F8 (read-only, returns parameter VERSION), configuration 0x300, opcode 0x308 (bits 7:0), address 0x30C (32 bits, read back as written), and buffer word i at 0x400 + 4*i.
- R2: Writing the configuration word with bit 0 set while idle starts a command. Bit 0 reads 1 from the next cycle until the transfer is over and then reads 0. Chip selects stay high and the serial clock stays low while idle.
- R3: Writes to the configuration register while a command runs are ignored. They neither change the running frame nor start a second one.
- R4: Every command begins with the 8-bit opcode sent most significant bit first. A command with address and data disabled and zero dummy bytes produces exactly 8 clock pulses.
- R5: When configuration bit 3 is set, three address bytes follow the opcode, taken from address bits 23:0, most significant byte first. When bit 3 is clear, no address bytes are sent.
- R6: Configuration bits 6:4 give a dummy byte count of 0 to 7. Each dummy byte is 8 clocks with data out held low, and the dummy bytes come after the address.
- R7: When bit 7 (data enable) is set and bit 8 is 0, bits 31:9 plus one bytes are sent from the buffer. Transfer byte k is bits 8*(k%4)+7 : 8*(k%4) of word k/4.
- R8: When bit 7 is set and bit 8 is 1, that many bytes are received, MSB first, and stored with the same little-endian packing. Buffer bytes past the length keep their old value.
- R9: The buffer holds 64 words when VERSION is 0x351 and 16 words otherwise. Offsets past the last word read as 0, and writes to them have no effect.
- R10: Configuration bits 2:1 pick which one of the four active-low chip selects is driven low. Data out is stable whenever the serial clock is high, and data in is sampled on the rising edge.
- R11: The chip select goes low at least HALF_DIV system clocks (one half serial period) before the first rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| spi_cs_n | output | 4 | Active-low chip selects |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The assertions assume that the register bus never issues a configuration write with bit 0 set in the same cycle as another access. They also assume that data in changes only while the serial clock is low. The bench honours both assumptions. Its flash model updates data in only at a falling clock edge, or at the edge where a chip select goes low. Bus accesses are issued one at a time, each lasting one cycle. Lengths programmed in the configuration word always fit the buffer depth of the instance under test.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    localparam int REG_AW = 12;

    localparam logic [REG_AW-1:0] OFF_IDENT  = 12'h1F8;
    localparam logic [REG_AW-1:0] OFF_CMDCFG = 12'h300;
    localparam logic [REG_AW-1:0] OFF_OPC    = 12'h308;
    localparam logic [REG_AW-1:0] OFF_FADDR  = 12'h30C;
    localparam logic [REG_AW-1:0] OFF_BUF    = 12'h400;

    // configuration word field positions
    localparam int CF_GO     = 0;
    localparam int CF_CS_LO  = 1;
    localparam int CF_AEN    = 3;
    localparam int CF_DMY_LO = 4;
    localparam int CF_DEN    = 7;
    localparam int CF_RD     = 8;
    localparam int CF_LEN_LO = 9;

    localparam logic [31:0] IDENT_DEEP = 32'h0000_0351;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_SETUP = 2'd1,
        SQ_SHIFT = 2'd2,
        SQ_HOLD  = 2'd3
    } sq_state_e;
endpackage

// File: rtl/sfc_halfdiv.sv
module sfc_halfdiv #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(HALF_DIV + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == CW'(HALF_DIV - 1));
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sfc_wordbuf.sv
module sfc_wordbuf #(
    parameter int WORDS = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_we,
    input  logic [$clog2(WORDS)-1:0]     bus_idx,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rword,
    input  logic                         eng_we,
    input  logic [$clog2(WORDS)+1:0]     eng_bidx,
    input  logic [7:0]                   eng_wbyte,
    output logic [7:0]                   eng_rbyte
);
    localparam int IW = $clog2(WORDS);

    logic [WORDS-1:0][31:0] mem_d, mem_q;
    logic [IW-1:0]          eng_w;
    logic [1:0]             eng_b;

    assign eng_w     = eng_bidx[IW+1:2];
    assign eng_b     = eng_bidx[1:0];
    assign bus_rword = mem_q[bus_idx];
    assign eng_rbyte = mem_q[eng_w][8*eng_b +: 8];

    always_comb begin
        mem_d = mem_q;
        if (bus_we) begin
            mem_d[bus_idx] = bus_wdata;
        end
        // engine byte store wins over a bus write to the same lane
        if (eng_we) begin
            mem_d[eng_w][8*eng_b +: 8] = eng_wbyte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end
endmodule

// File: rtl/sfc_shifter.sv
module sfc_shifter
    import sfc_pkg::*;
#(
    parameter int BUF_BYTES = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [1:0]                    cfg_cs,
    input  logic                          cfg_aen,
    input  logic [2:0]                    cfg_dummy,
    input  logic                          cfg_den,
    input  logic                          cfg_rd,
    input  logic [$clog2(BUF_BYTES)-1:0]  cfg_len_m1,
    input  logic [7:0]                    opcode,
    input  logic [23:0]                   faddr,
    input  logic                          tick,
    output logic                          run,
    output logic                          busy,
    output logic [3:0]                    cs_n,
    output logic                          sclk,
    output logic                          mosi,
    input  logic                          miso,
    output logic [$clog2(BUF_BYTES)-1:0]  buf_bidx,
    input  logic [7:0]                    buf_rbyte,
    output logic                          buf_we,
    output logic [7:0]                    buf_wbyte
);
    localparam int BW    = $clog2(BUF_BYTES);
    localparam int CNT_W = $clog2(BUF_BYTES + 12) + 1;

    typedef struct packed {
        sq_state_e        st;
        logic [3:0]       cs_n;
        logic             sclk;
        logic             mosi;
        logic [7:0]       sh;
        logic [7:0]       rx;
        logic [2:0]       bitn;
        logic [CNT_W-1:0] idx;
        logic [CNT_W-1:0] last;
        logic [CNT_W-1:0] dstart;
        logic             aen;
        logic             rd;
        logic [23:0]      adr;
    } sh_t;

    sh_t q, d;

    logic [CNT_W-1:0] nxt_idx;
    logic [CNT_W-1:0] dstart_v;
    logic [CNT_W-1:0] dlen_v;
    logic [7:0]       nb;

    assign run  = (q.st != SQ_IDLE);
    assign busy = run;
    assign cs_n = q.cs_n;
    assign sclk = q.sclk;
    assign mosi = q.mosi;

    always_comb begin
        nxt_idx  = q.idx + CNT_W'(1);
        dstart_v = CNT_W'(1) + (cfg_aen ? CNT_W'(3) : CNT_W'(0)) + CNT_W'(cfg_dummy);
        dlen_v   = cfg_den ? (CNT_W'(cfg_len_m1) + CNT_W'(1)) : CNT_W'(0);

        // receive stores at the current byte, transmit fetches the next one
        buf_bidx = q.rd ? BW'(q.idx - q.dstart) : BW'(nxt_idx - q.dstart);

        // content of the byte that follows the current one
        if (q.aen && nxt_idx == CNT_W'(1)) begin
            nb = q.adr[23:16];
        end else if (q.aen && nxt_idx == CNT_W'(2)) begin
            nb = q.adr[15:8];
        end else if (q.aen && nxt_idx == CNT_W'(3)) begin
            nb = q.adr[7:0];
        end else if (nxt_idx < q.dstart || q.rd) begin
            nb = 8'h00;
        end else begin
            nb = buf_rbyte;
        end

        d         = q;
        buf_we    = 1'b0;
        buf_wbyte = q.rx;

        unique case (q.st)
            SQ_IDLE: begin
                if (start) begin
                    d.st     = SQ_SETUP;
                    d.cs_n   = ~(4'b0001 << cfg_cs);
                    d.sclk   = 1'b0;
                    d.sh     = opcode;
                    d.mosi   = opcode[7];
                    d.bitn   = '0;
                    d.idx    = '0;
                    d.dstart = dstart_v;
                    d.last   = dstart_v + dlen_v - CNT_W'(1);
                    d.aen    = cfg_aen;
                    d.rd     = cfg_den & cfg_rd;
                    d.adr    = faddr;
                end
            end
            SQ_SETUP: begin
                if (tick) d.st = SQ_SHIFT;
            end
            SQ_SHIFT: begin
                if (tick) begin
                    if (!q.sclk) begin
                        d.sclk = 1'b1;
                        d.rx   = {q.rx[6:0], miso};
                    end else begin
                        d.sclk = 1'b0;
                        if (q.bitn == 3'd7) begin
                            if (q.rd && q.idx >= q.dstart) begin
                                buf_we = 1'b1;
                            end
                            if (q.idx == q.last) begin
                                d.st   = SQ_HOLD;
                                d.mosi = 1'b0;
                            end else begin
                                d.idx  = nxt_idx;
                                d.sh   = nb;
                                d.mosi = nb[7];
                                d.bitn = '0;
                            end
                        end else begin
                            d.bitn = q.bitn + 3'd1;
                            d.sh   = {q.sh[6:0], 1'b0};
                            d.mosi = q.sh[6];
                        end
                    end
                end
            end
            SQ_HOLD: begin
                if (tick) begin
                    d.st   = SQ_IDLE;
                    d.cs_n = '1;
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= SQ_IDLE;
            q.cs_n <= '1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/sfc_cmd_engine.sv
module sfc_cmd_engine
    import sfc_pkg::*;
#(
    parameter logic [31:0] VERSION  = 32'h0000_0351,
    parameter int          HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_en,
    input  logic        reg_we,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic [3:0]  spi_cs_n,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int WORDS     = (VERSION == IDENT_DEEP) ? 64 : 16;
    localparam int BUF_BYTES = WORDS * 4;
    localparam int IW        = $clog2(WORDS);
    localparam int BW        = $clog2(BUF_BYTES);
    localparam int CFG_TOP   = CF_LEN_LO + BW - 1;

    typedef struct packed {
        logic [7:0]  opc;
        logic [31:0] fadr;
        logic [CFG_TOP:1] cfg;
    } rg_t;

    rg_t rq, rd;

    logic          busy;
    logic          tick;
    logic          run;
    logic          start;
    logic          wr;
    logic          buf_hit;
    logic [31:0]   buf_rword;
    logic [BW-1:0] eng_bidx;
    logic [7:0]    eng_rbyte;
    logic          eng_we;
    logic [7:0]    eng_wbyte;

    assign wr      = reg_en && reg_we;
    assign buf_hit = (reg_addr >= OFF_BUF) &&
                     (reg_addr < OFF_BUF + 12'(4 * WORDS));
    assign start   = wr && (reg_addr == OFF_CMDCFG) && reg_wdata[CF_GO] && !busy;

    always_comb begin
        rd = rq;
        if (wr && reg_addr == OFF_OPC)   rd.opc  = reg_wdata[7:0];
        if (wr && reg_addr == OFF_FADDR) rd.fadr = reg_wdata;
        if (wr && reg_addr == OFF_CMDCFG && !busy) rd.cfg = reg_wdata[CFG_TOP:1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rq <= '0;
        else        rq <= rd;
    end

    always_comb begin
        reg_rdata = '0;
        if (buf_hit) begin
            reg_rdata = buf_rword;
        end else begin
            case (reg_addr)
                OFF_IDENT:  reg_rdata = VERSION;
                OFF_CMDCFG: reg_rdata = 32'({rq.cfg, busy});
                OFF_OPC:    reg_rdata = {24'h0, rq.opc};
                OFF_FADDR:  reg_rdata = rq.fadr;
                default:    reg_rdata = '0;
            endcase
        end
    end

    sfc_halfdiv #(.HALF_DIV(HALF_DIV)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    sfc_wordbuf #(.WORDS(WORDS)) buf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (wr && buf_hit),
        .bus_idx   (reg_addr[IW+1:2]),
        .bus_wdata (reg_wdata),
        .bus_rword (buf_rword),
        .eng_we    (eng_we),
        .eng_bidx  (eng_bidx),
        .eng_wbyte (eng_wbyte),
        .eng_rbyte (eng_rbyte)
    );

    sfc_shifter #(.BUF_BYTES(BUF_BYTES)) shf_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg_cs     (reg_wdata[CF_CS_LO +: 2]),
        .cfg_aen    (reg_wdata[CF_AEN]),
        .cfg_dummy  (reg_wdata[CF_DMY_LO +: 3]),
        .cfg_den    (reg_wdata[CF_DEN]),
        .cfg_rd     (reg_wdata[CF_RD]),
        .cfg_len_m1 (reg_wdata[CF_LEN_LO +: BW]),
        .opcode     (rq.opc),
        .faddr      (rq.fadr[23:0]),
        .tick       (tick),
        .run        (run),
        .busy       (busy),
        .cs_n       (spi_cs_n),
        .sclk       (spi_sclk),
        .mosi       (spi_mosi),
        .miso       (spi_miso),
        .buf_bidx   (eng_bidx),
        .buf_rbyte  (eng_rbyte),
        .buf_we     (eng_we),
        .buf_wbyte  (eng_wbyte)
    );
endmodule

// File: rtl/sfc_cmd_engine_chk.sv
module sfc_cmd_engine_chk
    import sfc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        reg_en,
    input logic        reg_we,
    input logic [11:0] reg_addr,
    input logic [31:0] reg_wdata,
    input logic [3:0]  spi_cs_n,
    input logic        spi_sclk,
    input logic        spi_mosi
);
    // R10: never more than one device selected
    assert_cs_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~spi_cs_n));

    // R2: idle means deselected with the clock parked low
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&spi_cs_n && !spi_sclk));

    // R2: a start write while idle makes the engine busy next cycle
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && reg_we && reg_addr == OFF_CMDCFG && reg_wdata[CF_GO] && !busy) |=> busy);

    // R10: data out holds while the clock is high
    assert_mosi_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    // R3: the selected device cannot change within a running command
    assert_busy_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(spi_cs_n));

    // R11: the first clock rise never coincides with the chip select falling
    assert_cs_lead_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(&spi_cs_n) |-> !spi_sclk);
endmodule

bind sfc_cmd_engine sfc_cmd_engine_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .spi_cs_n  (spi_cs_n),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi)
);

// File: tb/sfc_cmd_engine_tb_top.sv
module sfc_cmd_engine_tb_top;
    localparam logic [31:0] VER = 32'h0000_0300;
    localparam int HD    = 2;
    localparam int WORDS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  spi_cs_n;
    logic        spi_sclk;
    logic        spi_mosi;
    logic        spi_miso = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sfc_cmd_engine #(.VERSION(VER), .HALF_DIV(HD)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // flash model
    wire any_sel = ~&spi_cs_n;
    int   bitcnt = 0;
    int   sel_idx = -1;
    int   nframes = 0;
    logic [7:0] cap [0:511];
    time  t_fall, t_rise1;
    bit   got_rise;

    function automatic logic [7:0] resp(input int p);
        return 8'((p * 29 + 8'h5A) & 8'hFF);
    endfunction

    function automatic logic [7:0] wpat(input int k);
        return 8'((k * 13 + 7) & 8'hFF);
    endfunction

    always @(posedge any_sel) begin
        bitcnt   = 0;
        got_rise = 0;
        t_fall   = $time;
        nframes++;
        for (int i = 0; i < 4; i++) if (!spi_cs_n[i]) sel_idx = i;
        spi_miso = resp(0)[7];
    end

    always @(posedge spi_sclk) if (any_sel) begin
        if (!got_rise) begin t_rise1 = $time; got_rise = 1; end
        cap[bitcnt/8] = {cap[bitcnt/8][6:0], spi_mosi};
        bitcnt++;
    end

    always @(negedge spi_sclk) if (any_sel) begin
        spi_miso = resp(bitcnt / 8)[7 - (bitcnt % 8)];
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bw(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_en = 0; reg_we = 0;
    endtask

    task automatic br(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_en = 1; reg_we = 0; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_en = 0;
    endtask

    function automatic logic [31:0] cfgw(input int cs, input bit ae, input int dmy,
                                          input bit de, input bit rdir, input int len);
        return 32'(((len - 1) << 9) | (int'(rdir) << 8) | (int'(de) << 7) |
                   (dmy << 4) | (int'(ae) << 3) | (cs << 1) | 1);
    endfunction

    task automatic run_cmd(input int cs, input bit ae, input int dmy, input bit de,
                           input bit rdir, input int len, input logic [7:0] opc,
                           input logic [31:0] adr, input bit poke_busy);
        logic [31:0] v;
        int total, ds, f0;
        bw(12'h308, {24'h0, opc});
        bw(12'h30C, adr);
        f0 = nframes;
        bw(12'h300, cfgw(cs, ae, dmy, de, rdir, len));
        br(12'h300, v);
        chk(v[0] == 1'b1, "R2 busy after start", v, 32'h1);
        if (poke_busy) begin
            bw(12'h300, cfgw((cs + 1) % 4, 1'b1, 7, 1'b1, 1'b0, 8));
        end
        for (int n = 0; n < 20000; n++) begin
            br(12'h300, v);
            if (!v[0]) break;
        end
        chk(v[0] == 1'b0, "R2 start clears", v, 32'h0);
        ds    = 1 + (ae ? 3 : 0) + dmy;
        total = ds + (de ? len : 0);
        chk(nframes == f0 + 1, "R3 one frame", nframes - f0, 1);
        chk(bitcnt == 8 * total, "R4 clock count", bitcnt, 8 * total);
        chk(sel_idx == cs, "R10 chip select", sel_idx, cs);
        chk((t_rise1 - t_fall) >= HD * 4, "R11 cs lead", 32'(t_rise1 - t_fall), HD * 4);
        chk(cap[0] == opc, "R4 opcode", cap[0], opc);
        if (ae) begin
            chk(cap[1] == adr[23:16], "R5 addr hi", cap[1], adr[23:16]);
            chk(cap[2] == adr[15:8],  "R5 addr mid", cap[2], adr[15:8]);
            chk(cap[3] == adr[7:0],   "R5 addr lo", cap[3], adr[7:0]);
        end
        for (int k = (ae ? 4 : 1); k < ds; k++)
            chk(cap[k] == 8'h00, "R6 dummy zero", cap[k], 0);
        if (de && !rdir) begin
            for (int k = 0; k < len; k++)
                chk(cap[ds + k] == wpat(k), "R7 write byte", cap[ds + k], wpat(k));
        end
        if (de && rdir) begin
            for (int w = 0; w < WORDS; w++) begin
                logic [31:0] e;
                br(12'(12'h400 + 4 * w), v);
                for (int b = 0; b < 4; b++)
                    e[8*b +: 8] = (4*w + b < len) ? resp(ds + 4*w + b) : 8'hEE;
                chk(v == e, "R8 read word", v, e);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int lens [11] = '{1, 2, 3, 4, 5, 7, 8, 13, 31, 63, 64};
        repeat (3) @(negedge clk);
        #1;
        chk(&spi_cs_n && !spi_sclk, "R2 reset idle", {spi_cs_n, spi_sclk}, 32'h1e);
        rst_n = 1;
        br(12'h1F8, v); chk(v == VER, "R1 ident", v, VER);
        br(12'h300, v); chk(v == 0, "R2 cfg reset", v, 0);
        bw(12'h308, 32'hA5); br(12'h308, v); chk(v == 32'hA5, "R1 opcode reg", v, 32'hA5);
        bw(12'h30C, 32'hDEADBEEF); br(12'h30C, v); chk(v == 32'hDEADBEEF, "R1 addr reg", v, 32'hDEADBEEF);
        bw(12'h43C, 32'h11223344); br(12'h43C, v); chk(v == 32'h11223344, "R9 last word", v, 32'h11223344);
        bw(12'h440, 32'h55667788); br(12'h440, v); chk(v == 0, "R9 past depth", v, 0);

        // bare opcode, with a config write while busy
        run_cmd(2, 0, 0, 0, 0, 1, 8'h06, 32'h0, 1'b1);
        // address / dummy sweep
        for (int ae = 0; ae < 2; ae++)
            for (int dm = 0; dm < 8; dm++)
                run_cmd((ae * 8 + dm) % 4, ae[0], dm, 0, 0, 1, 8'(8'h80 + dm),
                        32'(32'h00A1B2C3 + dm * 32'h01010101), 1'b0);
        // write lengths
        for (int w = 0; w < WORDS; w++)
            bw(12'(12'h400 + 4 * w), {wpat(4*w+3), wpat(4*w+2), wpat(4*w+1), wpat(4*w)});
        foreach (lens[i]) run_cmd(i % 4, 1, i % 3, 1, 0, lens[i], 8'h02, 32'h123456, 1'b0);
        // read lengths
        foreach (lens[i]) begin
            for (int w = 0; w < WORDS; w++) bw(12'(12'h400 + 4 * w), 32'hEEEEEEEE);
            run_cmd((i + 1) % 4, i[0], i % 4, 1, 1, lens[i], 8'h0B, 32'h00FEDCBA, i == 3);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule